// File: doc/BRIEF.md
# Clustered Register File with Replicated Copies

This block holds the architectural integer registers for an in-order core that issues `NW` results per cycle and splits its execution lanes into `NCLU` clusters. A monolithic file would need `2*NW` read ports and `NW` write ports. Here each cluster keeps its own full copy of the registers, so each copy needs only the `2*NW/NCLU` read ports that its own lanes use. Every copy still accepts all `NW` writes. Result slot `i` belongs to cluster `i/(NW/NCLU)`, and read port `p` belongs to cluster `p/(2*NW/NCLU)`.

Results enter on a valid-qualified write bus with one lane per slot. The file accepts a write every cycle and has no back-pressure, so there is no ready on the write side. Within a cluster, forwarding is complete: a result from the cluster's own lanes can be read in the same cycle it is written. A result from a different cluster reaches the other copies only after `XDLY` cycles, where `XDLY` is 1 or 2. While such a result is still on its way, a read port that asks for that register lowers its ready flag. It does not return a stale value.

The write and read ports carry flat packed buses with one field per slot or port. The steering logic treats a low `rd_ready` as a stall request for the lane that owns that port.

Top module: `clustered_rf`

## Requirements
- R1: After reset, every register reads as zero with `rd_ready` high on every read port.
- R2: A write from slot `i` with `wr_valid[i]` high is readable on every read port of its own cluster from the next cycle on. It stays readable until a later write to the same register.
- R3: When several valid slots write the same register in one cycle, the slot with the highest index is the final value in every copy.
- R4: A read port whose address matches a valid write from its own cluster in the same cycle returns that write's data with `rd_ready` high. If several slots match, the youngest (highest-index) one applies.
- R5: A write made in cycle t by a slot of another cluster is readable with `rd_ready` high from cycle t+`XDLY` on.
- R6: `rd_ready` is low on a port when the youngest same-cycle write to its address comes from another cluster. With `XDLY`=2, it is also low when the last write to that address came from another cluster in the previous cycle.
- R7: Read port `p` serves cluster `p/(2*NW/NCLU)`, and slot `i` counts as part of cluster `i/(NW/NCLU)`. Each copy serves only its own cluster's ports.
- R8: Whenever no cross-cluster write is in flight, all copies hold identical contents. An idle cycle therefore makes every port agree on every register.
- R9: A slot with `wr_valid` low changes no register and affects no port, whatever its address and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset; clears every copy |
| wr_valid | input | NW | Per-slot write valid; bit i is slot i |
| wr_addr | input | NW*log2(NREG) | Per-slot destination register, slot i at bits [i*AW +: AW] |
| wr_data | input | NW*DW | Per-slot result, slot i at bits [i*DW +: DW] |
| rd_addr | input | 2*NW*log2(NREG) | Per-port source register, port p at bits [p*AW +: AW] |
| rd_data | output | 2*NW*DW | Per-port operand, port p at bits [p*DW +: DW] |
| rd_ready | output | 2*NW | Per-port operand-ready flag; low means the value is not yet visible |

## Verification
A copy that has drifted from the others shows up as a data mismatch on that cluster's ports, on the first read of the affected register after the in-flight window closes. A write that lands late, early or in the wrong slot order appears either as a wrong `rd_ready` in the one or two cycles after the write, or as a stale operand one cycle later. A lost squash of an older cross-cluster write shows up one cycle after the younger own-cluster write: the port returns the older value with `rd_ready` high.

// File: rtl/crf_pkg.sv
package crf_pkg;
  // Cluster index that owns lane `idx` when each cluster has `per` lanes.
  function automatic int unsigned owner_of(input int unsigned idx, input int unsigned per);
    return idx / per;
  endfunction
endpackage

// File: rtl/crf_xpipe.sv
// Carries the squashed write set to foreign copies; XDLY-1 register stages.
module crf_xpipe #(
  parameter int NW   = 4,
  parameter int AW   = 4,
  parameter int DW   = 32,
  parameter int XDLY = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NW-1:0]    in_vld,
  input  logic [NW*AW-1:0] in_addr,
  input  logic [NW*DW-1:0] in_data,
  output logic [NW-1:0]    out_vld,
  output logic [NW*AW-1:0] out_addr,
  output logic [NW*DW-1:0] out_data
);
  generate
    if (XDLY <= 1) begin : g_direct
      assign out_vld  = in_vld;
      assign out_addr = in_addr;
      assign out_data = in_data;
    end else begin : g_stage
      logic [NW-1:0]    vld_q;
      logic [NW*AW-1:0] addr_q;
      logic [NW*DW-1:0] data_q;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          vld_q  <= '0;
          addr_q <= '0;
          data_q <= '0;
        end else begin
          vld_q  <= in_vld;
          addr_q <= in_addr;
          data_q <= in_data;
        end
      end
      assign out_vld  = vld_q;
      assign out_addr = addr_q;
      assign out_data = data_q;
    end
  endgenerate
endmodule

// File: rtl/crf_replica.sv
// One full copy of the registers, with read ports for a single cluster.
module crf_replica #(
  parameter int NW   = 4,
  parameter int NREG = 16,
  parameter int DW   = 32,
  parameter int RPC  = 4,
  localparam int AW  = $clog2(NREG)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NW-1:0]      lnd_en,
  input  logic [NW*AW-1:0]   lnd_addr,
  input  logic [NW*DW-1:0]   lnd_data,
  input  logic [NW-1:0]      cur_en,
  input  logic [NW*AW-1:0]   cur_addr,
  input  logic [NW*DW-1:0]   cur_data,
  input  logic [RPC*AW-1:0]  rd_addr,
  output logic [RPC*DW-1:0]  rd_raw,
  output logic [NREG*DW-1:0] dump
);
  logic [DW-1:0] mem [NREG];

  // Delayed foreign writes first, then this cycle's own writes, so younger wins.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < NREG; r++) mem[r] <= '0;
    end else begin
      for (int i = 0; i < NW; i++)
        if (lnd_en[i]) mem[lnd_addr[i*AW +: AW]] <= lnd_data[i*DW +: DW];
      for (int i = 0; i < NW; i++)
        if (cur_en[i]) mem[cur_addr[i*AW +: AW]] <= cur_data[i*DW +: DW];
    end
  end

  generate
    for (genvar p = 0; p < RPC; p++) begin : g_rd
      assign rd_raw[p*DW +: DW] = mem[rd_addr[p*AW +: AW]];
    end
    for (genvar r = 0; r < NREG; r++) begin : g_dump
      assign dump[r*DW +: DW] = mem[r];
    end
  endgenerate
endmodule

// File: rtl/crf_rdsel.sv
// Operand select for one read port: own-cluster results or the copy, plus readiness.
module crf_rdsel #(
  parameter int NW  = 4,
  parameter int SPC = 2,
  parameter int DW  = 32,
  parameter int AW  = 4,
  parameter int CID = 0
) (
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    raw,
  input  logic [NW-1:0]    live,
  input  logic [NW*AW-1:0] w_addr,
  input  logic [NW*DW-1:0] w_data,
  input  logic [NW-1:0]    pend,
  input  logic [NW*AW-1:0] pend_addr,
  output logic [DW-1:0]    data,
  output logic             ready
);
  import crf_pkg::*;
  logic own_hit, blocked;

  always_comb begin
    data    = raw;
    own_hit = 1'b0;
    blocked = 1'b0;
    for (int i = 0; i < NW; i++) begin
      if (owner_of(i, SPC) == CID) begin
        // at most one live slot per address, so no priority is needed
        if (live[i] && w_addr[i*AW +: AW] == addr) begin
          data    = w_data[i*DW +: DW];
          own_hit = 1'b1;
        end
      end else begin
        if (live[i] && w_addr[i*AW +: AW] == addr) blocked = 1'b1;
        if (pend[i] && pend_addr[i*AW +: AW] == addr) blocked = 1'b1;
      end
    end
    ready = own_hit | ~blocked;
  end
endmodule

// File: rtl/clustered_rf.sv
module clustered_rf #(
  parameter int NW   = 4,
  parameter int NCLU = 2,
  parameter int NREG = 16,
  parameter int DW   = 32,
  parameter int XDLY = 2,
  localparam int AW  = $clog2(NREG),
  localparam int SPC = NW / NCLU,
  localparam int RPC = 2 * SPC,
  localparam int NRP = 2 * NW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NW-1:0]      wr_valid,
  input  logic [NW*AW-1:0]   wr_addr,
  input  logic [NW*DW-1:0]   wr_data,
  input  logic [NRP*AW-1:0]  rd_addr,
  output logic [NRP*DW-1:0]  rd_data,
  output logic [NRP-1:0]     rd_ready
);
  import crf_pkg::*;

  logic [NW-1:0]    live;
  logic [NW-1:0]    land_vld;
  logic [NW*AW-1:0] land_addr;
  logic [NW*DW-1:0] land_data;
  logic [NW-1:0]    pend;
  logic             busy;
  logic [NCLU*NREG*DW-1:0] rep_flat;

  // A slot survives only if no younger valid slot targets the same register.
  always_comb begin
    for (int i = 0; i < NW; i++) begin
      live[i] = wr_valid[i];
      for (int j = i + 1; j < NW; j++)
        if (wr_valid[j] && wr_addr[j*AW +: AW] == wr_addr[i*AW +: AW]) live[i] = 1'b0;
    end
  end

  crf_xpipe #(.NW(NW), .AW(AW), .DW(DW), .XDLY(XDLY)) u_xpipe (
    .clk(clk), .rst_n(rst_n),
    .in_vld(live), .in_addr(wr_addr), .in_data(wr_data),
    .out_vld(land_vld), .out_addr(land_addr), .out_data(land_data)
  );

  assign pend = (XDLY > 1) ? land_vld : '0;
  assign busy = |pend;

  generate
    for (genvar c = 0; c < NCLU; c++) begin : g_clu
      logic [NW-1:0]      own_m;
      logic [RPC*DW-1:0]  raw;
      logic [NREG*DW-1:0] dump;

      for (genvar i = 0; i < NW; i++) begin : g_mask
        assign own_m[i] = (owner_of(i, SPC) == c);
      end

      crf_replica #(.NW(NW), .NREG(NREG), .DW(DW), .RPC(RPC)) u_rep (
        .clk(clk), .rst_n(rst_n),
        .lnd_en(land_vld & ~own_m), .lnd_addr(land_addr), .lnd_data(land_data),
        .cur_en(live & own_m), .cur_addr(wr_addr), .cur_data(wr_data),
        .rd_addr(rd_addr[c*RPC*AW +: RPC*AW]),
        .rd_raw(raw),
        .dump(dump)
      );
      assign rep_flat[c*NREG*DW +: NREG*DW] = dump;

      for (genvar p = 0; p < RPC; p++) begin : g_port
        crf_rdsel #(.NW(NW), .SPC(SPC), .DW(DW), .AW(AW), .CID(c)) u_sel (
          .addr(rd_addr[(c*RPC + p)*AW +: AW]),
          .raw(raw[p*DW +: DW]),
          .live(live), .w_addr(wr_addr), .w_data(wr_data),
          .pend(pend), .pend_addr(land_addr),
          .data(rd_data[(c*RPC + p)*DW +: DW]),
          .ready(rd_ready[c*RPC + p])
        );
      end
    end
  endgenerate
endmodule

// File: rtl/clustered_rf_chk.sv
module clustered_rf_chk #(
  parameter int NW   = 4,
  parameter int NCLU = 2,
  parameter int NREG = 16,
  parameter int DW   = 32,
  localparam int AW  = $clog2(NREG),
  localparam int SPC = NW / NCLU,
  localparam int RPC = 2 * SPC,
  localparam int NRP = 2 * NW
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [NW-1:0]           wr_valid,
  input logic [NW*AW-1:0]        wr_addr,
  input logic [NW*DW-1:0]        wr_data,
  input logic [NRP*AW-1:0]       rd_addr,
  input logic [NRP*DW-1:0]       rd_data,
  input logic [NRP-1:0]          rd_ready,
  input logic [NCLU*NREG*DW-1:0] rep_flat,
  input logic                    busy
);
  logic [NRP-1:0] exp_fwd, exp_blk;
  logic [DW-1:0]  fwd_val [NRP];
  logic           rep_eq;

  // Youngest valid slot per port address, judged from the ports alone.
  always_comb begin
    for (int p = 0; p < NRP; p++) begin
      exp_fwd[p] = 1'b0;
      exp_blk[p] = 1'b0;
      fwd_val[p] = '0;
      for (int i = 0; i < NW; i++) begin
        if (wr_valid[i] && wr_addr[i*AW +: AW] == rd_addr[p*AW +: AW]) begin
          exp_fwd[p] = (i / SPC) == (p / RPC);
          exp_blk[p] = (i / SPC) != (p / RPC);
          fwd_val[p] = wr_data[i*DW +: DW];
        end
      end
    end
    rep_eq = 1'b1;
    for (int c = 1; c < NCLU; c++)
      if (rep_flat[c*NREG*DW +: NREG*DW] != rep_flat[0 +: NREG*DW]) rep_eq = 1'b0;
  end

  generate
    for (genvar p = 0; p < NRP; p++) begin : g_p
      p_own_fwd_r4: assert property (@(posedge clk) disable iff (!rst_n)
        exp_fwd[p] |-> (rd_ready[p] && rd_data[p*DW +: DW] == fwd_val[p]));
      p_foreign_wait_r6: assert property (@(posedge clk) disable iff (!rst_n)
        exp_blk[p] |-> !rd_ready[p]);
    end
  endgenerate

  p_copies_agree_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> rep_eq);

  p_idle_no_change_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|wr_valid) && !busy) |=> $stable(rep_flat));

  p_operand_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|wr_valid) && !busy && $past(!(|wr_valid)) && $past(!busy) && $stable(rd_addr))
      |-> $stable(rd_data));
endmodule

bind clustered_rf clustered_rf_chk #(.NW(NW), .NCLU(NCLU), .NREG(NREG), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
  .rd_addr(rd_addr), .rd_data(rd_data), .rd_ready(rd_ready),
  .rep_flat(rep_flat), .busy(busy)
);

// File: tb/clustered_rf_test.sv
`timescale 1ns/1ps
module clustered_rf_test;
  localparam int NW = 4, NCLU = 2, NREG = 16, DW = 32;
  localparam int AW = 4, SPC = NW / NCLU, RPC = 2 * SPC, NRP = 2 * NW;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic               rst_n;
  logic [NW-1:0]      wr_valid;
  logic [NW*AW-1:0]   wr_addr;
  logic [NW*DW-1:0]   wr_data;
  logic [NRP*AW-1:0]  rd_addr;
  logic [NRP*DW-1:0]  rd_data2, rd_data1;
  logic [NRP-1:0]     rd_ready2, rd_ready1;

  clustered_rf #(.NW(NW), .NCLU(NCLU), .NREG(NREG), .DW(DW), .XDLY(2)) uut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data2), .rd_ready(rd_ready2));

  clustered_rf #(.NW(NW), .NCLU(NCLU), .NREG(NREG), .DW(DW), .XDLY(1)) uut_d1 (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data1), .rd_ready(rd_ready1));

  // Staged stimulus, applied at the falling edge.
  logic          s_vld  [NW];
  logic [AW-1:0] s_waddr[NW];
  logic [DW-1:0] s_wdata[NW];
  logic [AW-1:0] s_raddr[NRP];

  // Behavioural reference: final value, last writer cluster and cycle per register.
  logic [DW-1:0] arch   [NREG];
  int            lw_cyc [NREG];
  int            lw_clu [NREG];
  int            cyc;
  int            n_run, n_fail;
  string         phase_tag;
  bit            done;

  task automatic clear_stim();
    for (int i = 0; i < NW; i++) begin s_vld[i] = 1'b0; s_waddr[i] = '0; s_wdata[i] = '0; end
    for (int p = 0; p < NRP; p++) s_raddr[p] = '0;
  endtask

  task automatic cmp_inst(input int dly, input logic [NRP*DW-1:0] d, input logic [NRP-1:0] rdy);
    for (int p = 0; p < NRP; p++) begin
      int c = p / RPC;
      int r = s_raddr[p];
      int young = -1, nwr = 0;
      bit inv_touch = 0;
      bit e_rdy;
      logic [DW-1:0] e_val;
      string tag;
      for (int i = 0; i < NW; i++) begin
        if (s_vld[i] && s_waddr[i] == r) begin young = i; nwr++; end
        if (!s_vld[i] && s_waddr[i] == r) inv_touch = 1;
      end
      e_val = arch[r];
      if (young >= 0) begin
        if (young / SPC == c) begin e_rdy = 1; e_val = s_wdata[young]; tag = "R4"; end
        else begin e_rdy = 0; tag = "R6"; end
        if (nwr > 1) tag = "R3";
      end else if (lw_clu[r] >= 0 && lw_clu[r] != c && (cyc - lw_cyc[r]) < dly) begin
        e_rdy = 0; tag = "R6";
      end else begin
        e_rdy = 1;
        tag = (lw_clu[r] >= 0 && lw_clu[r] != c) ? "R5" : "R2";
      end
      if (inv_touch) tag = "R9";
      if (phase_tag != "") tag = phase_tag;
      n_run++;
      if (rdy[p] !== e_rdy || (e_rdy && d[p*DW +: DW] !== e_val)) begin
        n_fail++;
        $display("FAIL %s xdly=%0d cyc=%0d port %0d reg %0d: ready %0b data %h, expected ready %0b data %h",
                 tag, dly, cyc, p, r, rdy[p], d[p*DW +: DW], e_rdy, e_val);
      end
    end
  endtask

  task automatic tick(input bit check);
    @(negedge clk);
    for (int i = 0; i < NW; i++) begin
      wr_valid[i]          = s_vld[i];
      wr_addr[i*AW +: AW]  = s_waddr[i];
      wr_data[i*DW +: DW]  = s_wdata[i];
    end
    for (int p = 0; p < NRP; p++) rd_addr[p*AW +: AW] = s_raddr[p];
    #1;
    if (check) begin
      cmp_inst(2, rd_data2, rd_ready2);
      cmp_inst(1, rd_data1, rd_ready1);
    end
    @(posedge clk);
    if (rst_n) begin
      for (int i = 0; i < NW; i++)
        if (s_vld[i]) begin
          arch[s_waddr[i]]   = s_wdata[i];
          lw_cyc[s_waddr[i]] = cyc;
          lw_clu[s_waddr[i]] = i / SPC;
        end
      cyc++;
    end
  endtask

  task automatic read_all_at(input int base);
    for (int p = 0; p < NRP; p++) s_raddr[p] = AW'(base + p);
  endtask

  task automatic read_one(input int r);
    for (int p = 0; p < NRP; p++) s_raddr[p] = AW'(r);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired after %0d checks (expected completion)", n_run);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    n_run = 0; n_fail = 0; cyc = 0; done = 0; phase_tag = "";
    for (int r = 0; r < NREG; r++) begin arch[r] = '0; lw_cyc[r] = 0; lw_clu[r] = -1; end
    wr_valid = '0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    clear_stim();
    rst_n = 1'b0;
    repeat (3) tick(0);
    rst_n = 1'b1;

    // R1: every register zero and ready after reset
    phase_tag = "R1";
    read_all_at(0); tick(1);
    read_all_at(8); tick(1);

    // R7: slot 0 (cluster 0) writes reg 5, all ports read it
    phase_tag = "R7";
    clear_stim(); read_one(5);
    s_vld[0] = 1; s_waddr[0] = 5; s_wdata[0] = 32'hA5A5_0005;
    tick(1);
    clear_stim(); read_one(5); tick(1); tick(1);
    // slot 3 (cluster 1) writes reg 6
    s_vld[3] = 1; s_waddr[3] = 6; s_wdata[3] = 32'h0000_0606; read_one(6);
    tick(1);
    clear_stim(); read_one(6); tick(1); tick(1);

    // R3: four slots write reg 9 in one cycle, youngest wins
    phase_tag = "R3";
    for (int i = 0; i < NW; i++) begin s_vld[i] = 1; s_waddr[i] = 9; s_wdata[i] = 32'h9000_0000 + i; end
    read_one(9); tick(1);
    clear_stim(); read_one(9); tick(1); tick(1);

    // R9: slot 3 invalid but aimed at reg 9; youngest valid is slot 2
    phase_tag = "R9";
    for (int i = 0; i < NW; i++) begin s_vld[i] = (i != 3); s_waddr[i] = 9; s_wdata[i] = 32'h9100_0000 + i; end
    read_one(9); tick(1);
    clear_stim(); s_waddr[3] = 9; s_wdata[3] = 32'hDEAD_BEEF; read_one(9); tick(1); tick(1);

    // R4/R5: own younger write after a foreign write to the same register
    phase_tag = "R4";
    clear_stim(); s_vld[2] = 1; s_waddr[2] = 3; s_wdata[2] = 32'h3333_0002; read_one(3); tick(1);
    clear_stim(); s_vld[1] = 1; s_waddr[1] = 3; s_wdata[1] = 32'h3333_0001; read_one(3); tick(1);
    phase_tag = "R5";
    clear_stim(); read_one(3); tick(1); tick(1);

    // Random traffic on a small register window to force hazards
    phase_tag = "";
    for (int k = 0; k < 400; k++) begin
      for (int i = 0; i < NW; i++) begin
        s_vld[i]   = ($urandom_range(0, 2) != 0);
        s_waddr[i] = AW'($urandom_range(0, 5));
        s_wdata[i] = $urandom;
      end
      for (int p = 0; p < NRP; p++) s_raddr[p] = AW'($urandom_range(0, 7));
      tick(1);
    end

    // R8: after idling, every cluster agrees on every register
    phase_tag = "R8";
    clear_stim(); tick(1); tick(1);
    for (int r = 0; r < NREG; r++) begin read_one(r); tick(1); end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule